// File: doc/BRIEF.md
# Peripheral signal routing controller

This block holds one 8-bit control register, written and read over a simple strobe bus, and uses it to route three shared pins. One pin carries a UART bit clock taken from one of two UART clock outputs. One pin carries a PWM waveform, built as a chosen logical mix of an 8-bit and a 16-bit PWM generator. One pin is shared by two timers. It can serve either timer directly, or it can serve one timer while the other timer's output is chained into the first timer's input.

The UARTs, PWM generators and timers sit outside the block and appear only as ports. A direction input from the port logic sets whether the shared timer pin acts as an input or an output. All routing is combinational from the register contents and the live inputs. A register write lands on the same clock edge that samples the strobe.

Top module: `pin_route_ctrl`

## Requirements
- R1: After reset `rd_data_o` reads 0x00. The PWM pin then follows `pwm8_i`, and the timer pin serves timer 1.
- R2: Bits 7..5 of `rd_data_o` always read 0, whatever was written to them.
- R3: When `wr_en_i` is high at a rising clock edge, bits 4..0 of `wr_data_i` appear on `rd_data_o` after that edge. When `wr_en_i` is low, the register holds its value.
- R4: When `uart1_clk_oe_i` or `uart2_clk_oe_i` is high, `uclk_pin_oe_o` is high. `uclk_pin_o` then equals `uart1_clk_i` if register bit 4 is 0, and `uart2_clk_i` if register bit 4 is 1.
- R5: When both UART clock enables are low, `uclk_pin_oe_o` and `uclk_pin_o` are 0 and bit 4 has no effect. `uart_clk_in_o` always equals `uclk_pin_i`.
- R6: Register bits 3..2 set `pwm_pin_o`: 00 gives `pwm8_i`, 01 gives `pwm16_i`, 10 gives their OR, 11 gives their AND.
- R7: Register bits 1..0 = 00 or 01 connect the timer pin to timer 1 or timer 2 respectively. With `tmr_dir_i`=0 that timer's input takes `tpin_i`. With `tmr_dir_i`=1 `tpin_o` carries that timer's output.
- R8: Register bits 1..0 = 10 make `tmr1_in_o` follow `tmr2_out_i`. With `tmr_dir_i`=0 `tmr2_in_o` takes `tpin_i`. With `tmr_dir_i`=1 `tpin_o` carries `tmr1_out_i`.
- R9: Register bits 1..0 = 11 make `tmr2_in_o` follow `tmr1_out_i`. With `tmr_dir_i`=0 `tmr1_in_o` takes `tpin_i`. With `tmr_dir_i`=1 `tpin_o` carries `tmr2_out_i`.
- R10: `tpin_oe_o` equals `tmr_dir_i`. When `tmr_dir_i` is 0, `tpin_o` is 0. Any timer input that is fed neither by the pin nor by the other timer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| uart1_clk_i | input | 1 | UART 1 clock output |
| uart2_clk_i | input | 1 | UART 2 clock output |
| uart1_clk_oe_i | input | 1 | UART 1 clock configured as output |
| uart2_clk_oe_i | input | 1 | UART 2 clock configured as output |
| uclk_pin_i | input | 1 | Shared UART clock pin, input value |
| uclk_pin_o | output | 1 | Shared UART clock pin, output value |
| uclk_pin_oe_o | output | 1 | Shared UART clock pin output enable |
| uart_clk_in_o | output | 1 | External clock passed to the UARTs |
| pwm8_i | input | 1 | 8-bit PWM generator output |
| pwm16_i | input | 1 | 16-bit PWM generator output |
| pwm_pin_o | output | 1 | Final PWM pin |
| tmr_dir_i | input | 1 | Timer pin direction, 1 = output |
| tpin_i | input | 1 | Shared timer pin, input value |
| tpin_o | output | 1 | Shared timer pin, output value |
| tpin_oe_o | output | 1 | Shared timer pin output enable |
| tmr1_out_i | input | 1 | Timer 1 output |
| tmr2_out_i | input | 1 | Timer 2 output |
| tmr1_in_o | output | 1 | Timer 1 input |
| tmr2_in_o | output | 1 | Timer 2 input |

## Verification
The bench walks all 32 writable register values, each written with varying upper bits. Under each value it applies every combination of the eleven single-bit inputs. This catches the cascade modes, where swapping the two timers would feed a timer's own output back into itself or send the wrong timer to the pin. It also catches the inactive direction, where a design that failed to gate the pin would drive `tpin_o` while the pin is an input, or would leave the unused timer input floating at the pin value. With both UART enables low, a design that still honoured bit 4 would drive the shared clock pin against an external clock. Writes with the strobe low, and ones to the reserved bits, expose a register that latches without the strobe or stores bits that must read as zero.

// File: rtl/pin_route_pkg.sv
`timescale 1ns/1ps
package pin_route_pkg;
  localparam int REG_W    = 8;
  localparam int UCLK_BIT = 4;
  localparam int PWM_LSB  = 2;
  localparam int TMR_LSB  = 0;
  localparam int CFG_W    = UCLK_BIT + 1;
  localparam logic [REG_W-1:0] WR_MASK = REG_W'((1 << CFG_W) - 1);

  typedef enum logic [1:0] {
    PWM_SHORT = 2'b00,
    PWM_LONG  = 2'b01,
    PWM_OR    = 2'b10,
    PWM_AND   = 2'b11
  } pwm_mode_e;

  typedef enum logic [1:0] {
    TMR_T1       = 2'b00,
    TMR_T2       = 2'b01,
    TMR_T2_TO_T1 = 2'b10,
    TMR_T1_TO_T2 = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      uclk_sel;
    pwm_mode_e pwm;
    tmr_mode_e tmr;
  } route_cfg_t;
endpackage

// File: rtl/pin_route_reg.sv
`timescale 1ns/1ps
module pin_route_reg #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     MASK = '1,
  parameter logic [W-1:0]     RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RST & MASK;
    else if (wr_en_i) q <= wr_data_i & MASK;
  end

  assign q_o = q;
endmodule

// File: rtl/pin_route_uclk.sv
`timescale 1ns/1ps
module pin_route_uclk #(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src_clk_i,
  input  logic [N_SRC-1:0] src_oe_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             ext_clk_o
);
  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (sel_i == SEL_W'(i)) picked = src_clk_i[i];
  end

  // pin only driven while some UART presents its clock outward
  assign pin_oe_o  = |src_oe_i;
  assign pin_o     = pin_oe_o & picked;
  assign ext_clk_o = pin_i;
endmodule

// File: rtl/pin_route_pwm.sv
`timescale 1ns/1ps
module pin_route_pwm
  import pin_route_pkg::*;
(
  input  pwm_mode_e mode_i,
  input  logic      short_i,
  input  logic      long_i,
  output logic      pin_o
);
  always_comb begin
    unique case (mode_i)
      PWM_SHORT: pin_o = short_i;
      PWM_LONG:  pin_o = long_i;
      PWM_OR:    pin_o = short_i | long_i;
      PWM_AND:   pin_o = short_i & long_i;
      default:   pin_o = short_i;
    endcase
  end
endmodule

// File: rtl/pin_route_tmr.sv
`timescale 1ns/1ps
module pin_route_tmr
  import pin_route_pkg::*;
(
  input  tmr_mode_e mode_i,
  input  logic      dir_out_i,
  input  logic      pin_i,
  input  logic      t1_out_i,
  input  logic      t2_out_i,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      t1_in_o,
  output logic      t2_in_o
);
  logic pin_in;

  assign pin_in   = ~dir_out_i & pin_i;
  assign pin_oe_o = dir_out_i;

  always_comb begin
    t1_in_o = 1'b0;
    t2_in_o = 1'b0;
    pin_o   = 1'b0;
    unique case (mode_i)
      TMR_T1: begin
        t1_in_o = pin_in;
        pin_o   = dir_out_i & t1_out_i;
      end
      TMR_T2: begin
        t2_in_o = pin_in;
        pin_o   = dir_out_i & t2_out_i;
      end
      TMR_T2_TO_T1: begin
        t1_in_o = t2_out_i;
        t2_in_o = pin_in;
        pin_o   = dir_out_i & t1_out_i;
      end
      TMR_T1_TO_T2: begin
        t2_in_o = t1_out_i;
        t1_in_o = pin_in;
        pin_o   = dir_out_i & t2_out_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pin_route_ctrl.sv
`timescale 1ns/1ps
module pin_route_ctrl
  import pin_route_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       uart1_clk_i,
  input  logic       uart2_clk_i,
  input  logic       uart1_clk_oe_i,
  input  logic       uart2_clk_oe_i,
  input  logic       uclk_pin_i,
  output logic       uclk_pin_o,
  output logic       uclk_pin_oe_o,
  output logic       uart_clk_in_o,
  input  logic       pwm8_i,
  input  logic       pwm16_i,
  output logic       pwm_pin_o,
  input  logic       tmr_dir_i,
  input  logic       tpin_i,
  output logic       tpin_o,
  output logic       tpin_oe_o,
  input  logic       tmr1_out_i,
  input  logic       tmr2_out_i,
  output logic       tmr1_in_o,
  output logic       tmr2_in_o
);
  logic [REG_W-1:0] reg_q;
  route_cfg_t       cfg;

  pin_route_reg #(
    .W   (REG_W),
    .MASK(WR_MASK),
    .RST ('0)
  ) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .q_o      (reg_q)
  );

  assign rd_data_o = reg_q;
  assign cfg       = route_cfg_t'(reg_q[CFG_W-1:0]);

  pin_route_uclk #(.N_SRC(2)) u_uclk (
    .src_clk_i({uart2_clk_i, uart1_clk_i}),
    .src_oe_i ({uart2_clk_oe_i, uart1_clk_oe_i}),
    .sel_i    (cfg.uclk_sel),
    .pin_i    (uclk_pin_i),
    .pin_o    (uclk_pin_o),
    .pin_oe_o (uclk_pin_oe_o),
    .ext_clk_o(uart_clk_in_o)
  );

  pin_route_pwm u_pwm (
    .mode_i (cfg.pwm),
    .short_i(pwm8_i),
    .long_i (pwm16_i),
    .pin_o  (pwm_pin_o)
  );

  pin_route_tmr u_tmr (
    .mode_i   (cfg.tmr),
    .dir_out_i(tmr_dir_i),
    .pin_i    (tpin_i),
    .t1_out_i (tmr1_out_i),
    .t2_out_i (tmr2_out_i),
    .pin_o    (tpin_o),
    .pin_oe_o (tpin_oe_o),
    .t1_in_o  (tmr1_in_o),
    .t2_in_o  (tmr2_in_o)
  );
endmodule

// File: rtl/pin_route_chk.sv
`timescale 1ns/1ps
module pin_route_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       uart1_clk_oe_i,
  input logic       uart2_clk_oe_i,
  input logic       uclk_pin_o,
  input logic       uclk_pin_oe_o,
  input logic       pwm8_i,
  input logic       pwm16_i,
  input logic       pwm_pin_o,
  input logic       tmr_dir_i,
  input logic       tpin_o,
  input logic       tpin_oe_o,
  input logic       tmr1_out_i,
  input logic       tmr2_out_i,
  input logic       tmr1_in_o,
  input logic       tmr2_in_o
);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:5] == 3'b000);

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[4:0] == $past(wr_data_i[4:0]));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  assert_uclk_input_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uart1_clk_oe_i || uart2_clk_oe_i) |-> !uclk_pin_oe_o && !uclk_pin_o);

  assert_pwm_and_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3:2] == 2'b11 |-> pwm_pin_o == (pwm8_i & pwm16_i));

  assert_pwm_or_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3:2] == 2'b10 |-> pwm_pin_o == (pwm8_i | pwm16_i));

  assert_chain_t2_t1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1:0] == 2'b10 |-> tmr1_in_o == tmr2_out_i);

  assert_chain_t1_t2_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1:0] == 2'b11 |-> tmr2_in_o == tmr1_out_i);

  assert_dir_in_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_dir_i |-> !tpin_oe_o && !tpin_o);

  assert_dir_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_dir_i |-> tpin_oe_o);
endmodule

bind pin_route_ctrl pin_route_chk u_chk (.*);

// File: tb/sim_pin_route_ctrl.sv
`timescale 1ns/1ps
module sim_pin_route_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       u1 = 0, u2 = 0, oe1 = 0, oe2 = 0, upin = 0;
  logic       uclk_o, uclk_oe, uclk_in;
  logic       p8 = 0, p16 = 0, pwm;
  logic       dir = 0, tpin = 0, t1o = 0, t2o = 0;
  logic       tp_o, tp_oe, t1in, t2in;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] mdl_reg = 8'h00;

  always #2 clk = ~clk;

  pin_route_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .uart1_clk_i(u1), .uart2_clk_i(u2),
    .uart1_clk_oe_i(oe1), .uart2_clk_oe_i(oe2),
    .uclk_pin_i(upin), .uclk_pin_o(uclk_o), .uclk_pin_oe_o(uclk_oe),
    .uart_clk_in_o(uclk_in),
    .pwm8_i(p8), .pwm16_i(p16), .pwm_pin_o(pwm),
    .tmr_dir_i(dir), .tpin_i(tpin), .tpin_o(tp_o), .tpin_oe_o(tp_oe),
    .tmr1_out_i(t1o), .tmr2_out_i(t2o), .tmr1_in_o(t1in), .tmr2_in_o(t2in)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference for all outputs, given model register and inputs
  task automatic compare_all();
    int pm = mdl_reg[3:2];
    int tm = mdl_reg[1:0];
    logic e_pwm, e_uo, e_uoe, e_po, e_t1, e_t2;
    string treq;
    chk("R2", "rd_data", rd_data, mdl_reg);
    e_uoe = oe1 | oe2;
    e_uo  = e_uoe ? (mdl_reg[4] ? u2 : u1) : 1'b0;
    chk(e_uoe ? "R4" : "R5", "uclk_oe", 8'(uclk_oe), 8'(e_uoe));
    chk(e_uoe ? "R4" : "R5", "uclk_o", 8'(uclk_o), 8'(e_uo));
    chk("R5", "uart_clk_in", 8'(uclk_in), 8'(upin));
    case (pm)
      0: e_pwm = p8;
      1: e_pwm = p16;
      2: e_pwm = p8 | p16;
      default: e_pwm = p8 & p16;
    endcase
    chk("R6", "pwm_pin", 8'(pwm), 8'(e_pwm));
    e_t1 = 0; e_t2 = 0; e_po = 0;
    case (tm)
      0: begin treq = "R7"; if (dir) e_po = t1o; else e_t1 = tpin; end
      1: begin treq = "R7"; if (dir) e_po = t2o; else e_t2 = tpin; end
      2: begin treq = "R8"; e_t1 = t2o; if (dir) e_po = t1o; else e_t2 = tpin; end
      default: begin treq = "R9"; e_t2 = t1o; if (dir) e_po = t2o; else e_t1 = tpin; end
    endcase
    chk("R10", "tpin_oe", 8'(tp_oe), 8'(dir));
    chk(dir ? treq : "R10", "tpin_o", 8'(tp_o), 8'(e_po));
    chk(treq, "tmr1_in", 8'(t1in), 8'(e_t1));
    chk(treq, "tmr2_in", 8'(t2in), 8'(e_t2));
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    mdl_reg = d & 8'h1F;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = ~d;
    #1;
    chk("R3", "rd_after_write", rd_data, mdl_reg);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    #5;
    chk("R1", "rd_in_reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    p8 = 1; p16 = 0; dir = 0; tpin = 1;
    #1;
    chk("R1", "rd_after_reset", rd_data, 8'h00);
    chk("R1", "pwm_default", 8'(pwm), 8'h01);
    chk("R1", "tmr1_default", 8'(t1in), 8'h01);
    compare_all();

    // R2: reserved bits dropped
    do_write(8'hFF);
    chk("R2", "rsvd_masked", rd_data, 8'h1F);

    // R3: no strobe, no change
    @(negedge clk);
    wr_data = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R3", "hold_without_strobe", rd_data, 8'h1F);

    // full sweep: every register value under every input combination
    for (int r = 0; r < 32; r++) begin
      do_write({3'(r) ^ 3'b101, 5'(r)});
      for (int v = 0; v < 2048; v++) begin
        @(negedge clk);
        {upin, t2o, t1o, tpin, dir, p16, p8, oe2, oe1, u2, u1} = 11'(v);
        #1;
        compare_all();
      end
    end

    // R3: write followed by write with strobe low in between
    do_write(8'h0A);
    @(negedge clk);
    wr_data = 8'h15;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R3", "hold_after_write", rd_data, 8'h0A);
    finish_run();
  end
endmodule